// File: doc/BRIEF.md
# Hierarchical Statechart Configuration Stepper

This block keeps the set of active states of a small hierarchical statechart and moves it forward by one microstep on each clock edge where it is not stalled. The chart itself is fixed at elaboration: each transition carries an exit mask and a target mask over the states. Each state carries a parent index, a kind (atomic, compound or parallel) and an optional named initial child. Logic outside the block picks the transitions to fire. It drives them as a one-hot-or-more vector of selected transitions. The block works out which active states leave, which states enter, and the resulting configuration.

States are numbered in document order. Bit s of every state vector is state s, and state 0 is the root. A parent always has a lower number than its children. Bit t of the selection vector is transition t. Entry completes in two directions. Targeting a nested state drags its compound and parallel ancestors into the complete entry set. Entering a compound state pulls in its default child, and entering a parallel state pulls in every region. After reset the block starts itself: the root and the root's default child are entered on the first unstalled edge. The root then stays active for as long as the `completed` input is low.

The default chart has eight states. State 0 is the root (compound, no named initial child) and state 1 is IDLE (atomic). State 2 is RUN (compound, named initial child 4), with atomic children 3 (SLOW) and 4 (FAST). State 5 is PAR (parallel), with atomic regions 6 and 7. It has seven transitions:

| Transition | From | To |
|------------|------|----|
| t0 | IDLE | RUN |
| t1 | FAST | SLOW |
| t2 | RUN | PAR |
| t3 | region 6 | region 6 (self) |
| t4 | PAR | SLOW |
| t5 | RUN | IDLE |
| t6 | region 7 | region 7 (self) |

Top module: `hsm_config_stepper`

## Requirements
- R1: While `rst_n` is low at a rising edge, all bits of `active_o` clear and the internal start-up flag of the root is set. The reset is synchronous and active low.
- R2: On an edge where `stall` is high, `active_o` and the start-up flag keep their values. The combinational `entry_o` and `exit_o` still reflect the current inputs.
- R3: Bit s of `exit_o` is 1 exactly when state s is active and at least one selected transition has bit s set in its exit mask.
- R4: Bit s of `entry_o` is 1 exactly when state s is in the complete entry set and is either exiting or inactive. A self-transition on an active state therefore shows the state in both `exit_o` and `entry_o`.
- R5: On an unstalled edge, bit s of `active_o` (s ≥ 1) becomes 1 when the state was in the complete entry set, or was active and not exiting.
- R6: On an unstalled edge, `active_o[0]` becomes the inverse of `completed`.
- R7: When a parallel state is in the complete entry set, all of its children are in it. In the default chart, entering PAR (state 5) enters states 6 and 7.
- R8: A child of a compound parent is entered by default completion only when three conditions hold. First, it must be the parent's named initial child, or the parent's first child in document order if no child is named. Second, the parent must be in the entry set. Third, no sibling may be active and staying, or targeted by a selected transition. In the default chart, entering RUN enters state 4, and entering SLOW through t4 does not also enter FAST.
- R9: A non-root state targeted by a selected transition puts each of its compound or parallel ancestors into the complete entry set. An ancestor that is already active and not exiting is not re-entered.
- R10: After reset, with no transition selected, the root and its default child (state 1 in the default chart) appear in `entry_o` until the first unstalled edge. After that edge `active_o` is 0x03, and the start-up entry does not recur.
- R11: For legal transition selections, every active compound state has exactly one active child after each step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | High holds the configuration for this edge |
| completed | input | 1 | High lets the root state drop on the next unstalled edge |
| trans_sel | input | N_T | Selected transitions, bit t is transition t |
| active_o | output | N_S | Current configuration, bit s is state s |
| entry_o | output | N_S | States entered by the coming microstep |
| exit_o | output | N_S | States exited by the coming microstep |

## Verification
The hardest situation to reach is a default completion that must be suppressed: a compound parent is re-entered while a sibling of its default child is being targeted in the same microstep. The stimulus first leaves RUN for the parallel region. It then fires the transition from PAR straight into SLOW, so that RUN is entered from outside while FAST is neither active nor targeted. Self-transitions inside the parallel region, fired alone and together, cover states that appear in both the exit and entry sets. A stalled step with a live selection shows that the sets are computed without being committed.

// File: rtl/hsm_cfg_pkg.sv
// Package: hsm_cfg_pkg
// Shared state-kind codes and the default chart used by the stepper.
// Assumes states are numbered in document order, with the root at index 0.
package hsm_cfg_pkg;

    localparam logic [1:0] K_ATOMIC   = 2'd0;
    localparam logic [1:0] K_COMPOUND = 2'd1;
    localparam logic [1:0] K_PARALLEL = 2'd2;

    localparam int DEF_N_S = 8;
    localparam int DEF_N_T = 7;

    typedef int idx_arr_t [DEF_N_S];

    // parent of each state (entry 0, the root, is ignored)
    localparam idx_arr_t DEF_PARENT = '{0, 0, 0, 2, 2, 0, 5, 5};
    // named initial child per state, 0 means none named
    localparam idx_arr_t DEF_INIT   = '{0, 0, 4, 0, 0, 0, 0, 0};

    // kind per state, state 7 in the top slice
    localparam logic [DEF_N_S-1:0][1:0] DEF_KIND =
        {K_ATOMIC, K_ATOMIC, K_PARALLEL, K_ATOMIC,
         K_ATOMIC, K_COMPOUND, K_ATOMIC, K_COMPOUND};

    // per-transition exit and target masks, transition 6 in the top slice
    localparam logic [DEF_N_T-1:0][DEF_N_S-1:0] DEF_EXIT =
        {8'h80, 8'h1C, 8'hE0, 8'h40, 8'h1C, 8'h10, 8'h02};
    localparam logic [DEF_N_T-1:0][DEF_N_S-1:0] DEF_TARGET =
        {8'h80, 8'h02, 8'h08, 8'h40, 8'h20, 8'h08, 8'h04};

endpackage

// File: rtl/hsm_exit_set.sv
// Module: hsm_exit_set
// Computes the set of states left by the selected transitions.
// Assumes exit masks are constant; only active states can leave.
module hsm_exit_set #(
    parameter int N_S = 8,
    parameter int N_T = 7,
    parameter logic [N_T-1:0][N_S-1:0] EXIT_MASK = '0
) (
    input  logic [N_T-1:0] sel_i,
    input  logic [N_S-1:0] act_i,
    output logic [N_S-1:0] ext_o
);

    // Purpose: OR the exit masks of all selected transitions, gated by activity.
    always_comb begin
        logic [N_S-1:0] marked;
        marked = '0;
        for (int t = 0; t < N_T; t++) begin
            if (sel_i[t]) begin
                marked = marked | EXIT_MASK[t];
            end
        end
        ext_o = marked & act_i;
    end

endmodule

// File: rtl/hsm_entry_set.sv
// Module: hsm_entry_set
// Computes the complete entry set (upward and downward completion) and
// the entry set. Assumes each parent index is lower than its children's,
// so one downward pass and one upward pass resolve the whole tree.
module hsm_entry_set
    import hsm_cfg_pkg::*;
#(
    parameter int N_S = 8,
    parameter int N_T = 7,
    parameter logic [N_T-1:0][N_S-1:0] TARGET_MASK = '0,
    parameter int PARENT [N_S] = '{default: 0},
    parameter int INIT_CHILD [N_S] = '{default: 0},
    parameter logic [N_S-1:0][1:0] KIND = '0
) (
    input  logic [N_T-1:0] sel_i,
    input  logic [N_S-1:0] act_i,
    input  logic [N_S-1:0] ext_i,
    input  logic           boot_i,
    output logic [N_S-1:0] ces_o,
    output logic [N_S-1:0] ent_o
);

    // Build the child mask of each state from the parent table.
    function automatic logic [N_S-1:0][N_S-1:0] build_children();
        logic [N_S-1:0][N_S-1:0] m;
        m = '0;
        for (int p = 0; p < N_S; p++) begin
            for (int c = 1; c < N_S; c++) begin
                if (PARENT[c] == p) begin
                    m[p][c] = 1'b1;
                end
            end
        end
        return m;
    endfunction

    localparam logic [N_S-1:0][N_S-1:0] CHILDREN = build_children();

    logic [N_S-1:0] hit;
    logic [N_S-1:0] up;

    // Purpose: mark every state named by the target mask of a selected transition.
    always_comb begin
        hit = '0;
        for (int t = 0; t < N_T; t++) begin
            if (sel_i[t]) begin
                hit = hit | TARGET_MASK[t];
            end
        end
    end

    // Purpose: upward completion, a container joins when any child joins.
    always_comb begin
        up = '0;
        for (int s = N_S - 1; s >= 1; s--) begin
            up[s] = hit[s];
            if (KIND[s] != K_ATOMIC && (|(up & CHILDREN[s]))) begin
                up[s] = 1'b1;
            end
        end
    end

    // Purpose: downward completion from the root, then the entry filter.
    always_comb begin
        ces_o    = '0;
        ent_o    = '0;
        ces_o[0] = boot_i;
        ent_o[0] = boot_i & (ext_i[0] | ~act_i[0]);
        for (int s = 1; s < N_S; s++) begin
            logic           dc;
            logic           is_first;
            logic [N_S-1:0] sib;
            dc       = 1'b0;
            is_first = 1'b0;
            sib      = '0;
            for (int p = 0; p < s; p++) begin
                if (PARENT[s] == p) begin
                    if (KIND[p] == K_PARALLEL) begin
                        dc = ces_o[p];
                    end else if (KIND[p] == K_COMPOUND) begin
                        is_first = (INIT_CHILD[p] != 0) ? (INIT_CHILD[p] == s)
                                                        : (s == p + 1);
                        sib      = CHILDREN[p];
                        sib[s]   = 1'b0;
                        dc = is_first & ent_o[p]
                           & ~(|(sib & ((act_i & ~ext_i) | up)));
                    end
                end
            end
            ces_o[s] = up[s] | dc;
            ent_o[s] = ces_o[s] & (ext_i[s] | ~act_i[s]);
        end
    end

endmodule

// File: rtl/hsm_config_reg.sv
// Module: hsm_config_reg
// Holds the active vector and the root start-up flag.
// Assumes a synchronous active-low reset; stall freezes both registers.
module hsm_config_reg #(
    parameter int N_S = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stall,
    input  logic           completed,
    input  logic [N_S-1:0] ces_i,
    input  logic [N_S-1:0] ext_i,
    output logic [N_S-1:0] act_o,
    output logic           boot_o
);

    logic [N_S-1:0] nxt;

    // Purpose: next configuration, root follows completed, others enter or stay.
    always_comb begin
        nxt    = ces_i | (act_o & ~ext_i);
        nxt[0] = ~completed;
    end

    // Purpose: register the configuration and retire the start-up flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_o  <= '0;
            boot_o <= 1'b1;
        end else if (!stall) begin
            act_o  <= nxt;
            boot_o <= 1'b0;
        end
    end

endmodule

// File: rtl/hsm_config_stepper.sv
// Module: hsm_config_stepper
// Advances a hierarchical statechart configuration by one microstep per
// unstalled clock. The chart is fixed by the parameters; the caller picks
// a legal, conflict-free transition set each cycle.
module hsm_config_stepper
    import hsm_cfg_pkg::*;
#(
    parameter int N_S = DEF_N_S,
    parameter int N_T = DEF_N_T,
    parameter logic [N_T-1:0][N_S-1:0] EXIT_MASK   = DEF_EXIT,
    parameter logic [N_T-1:0][N_S-1:0] TARGET_MASK = DEF_TARGET,
    parameter int PARENT [N_S]     = DEF_PARENT,
    parameter int INIT_CHILD [N_S] = DEF_INIT,
    parameter logic [N_S-1:0][1:0] KIND = DEF_KIND
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stall,
    input  logic           completed,
    input  logic [N_T-1:0] trans_sel,
    output logic [N_S-1:0] active_o,
    output logic [N_S-1:0] entry_o,
    output logic [N_S-1:0] exit_o
);

    logic [N_S-1:0] ces;
    logic           boot;

    hsm_exit_set #(
        .N_S(N_S), .N_T(N_T), .EXIT_MASK(EXIT_MASK)
    ) u_exit (
        .sel_i(trans_sel), .act_i(active_o), .ext_o(exit_o)
    );

    hsm_entry_set #(
        .N_S(N_S), .N_T(N_T), .TARGET_MASK(TARGET_MASK),
        .PARENT(PARENT), .INIT_CHILD(INIT_CHILD), .KIND(KIND)
    ) u_entry (
        .sel_i(trans_sel), .act_i(active_o), .ext_i(exit_o),
        .boot_i(boot), .ces_o(ces), .ent_o(entry_o)
    );

    hsm_config_reg #(
        .N_S(N_S)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .stall(stall), .completed(completed),
        .ces_i(ces), .ext_i(exit_o), .act_o(active_o), .boot_o(boot)
    );

endmodule

// File: rtl/hsm_config_stepper_chk.sv
// Module: hsm_config_stepper_chk
// Checker bound to the stepper; watches its ports only.
module hsm_config_stepper_chk
    import hsm_cfg_pkg::*;
#(
    parameter int N_S = 8,
    parameter int PARENT [N_S] = '{default: 0},
    parameter logic [N_S-1:0][1:0] KIND = '0
) (
    input logic           clk,
    input logic           rst_n,
    input logic           stall,
    input logic           completed,
    input logic [N_S-1:0] active_o,
    input logic [N_S-1:0] entry_o,
    input logic [N_S-1:0] exit_o
);

    function automatic logic [N_S-1:0][N_S-1:0] kids();
        logic [N_S-1:0][N_S-1:0] m;
        m = '0;
        for (int p = 0; p < N_S; p++) begin
            for (int c = 1; c < N_S; c++) begin
                if (PARENT[c] == p) begin
                    m[p][c] = 1'b1;
                end
            end
        end
        return m;
    endfunction

    localparam logic [N_S-1:0][N_S-1:0] KIDS = kids();

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (active_o == '0));

    p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(active_o));

    p_exit_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_o & ~active_o) == '0);

    p_entry_filter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_o & active_o & ~exit_o) == '0);

    p_next_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (active_o[N_S-1:1] == ($past(entry_o[N_S-1:1])
                   | ($past(active_o[N_S-1:1]) & ~$past(exit_o[N_S-1:1])))));

    p_root_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (active_o[0] == !$past(completed)));

    for (genvar s = 0; s < N_S; s++) begin : g_cmp
        if (KIND[s] == K_COMPOUND) begin : g_on
            p_one_child_r11: assert property (@(posedge clk) disable iff (!rst_n)
                active_o[s] |-> ($countones(active_o & KIDS[s]) == 1));
        end
    end

endmodule

bind hsm_config_stepper hsm_config_stepper_chk #(
    .N_S(N_S), .PARENT(PARENT), .KIND(KIND)
) u_chk (.*);

// File: tb/hsm_config_stepper_tb.sv
// Bench: walks a vector table of microsteps on the default chart, then
// runs directed reset and start-up cases.
module hsm_config_stepper_tb;

    localparam int NS = 8;
    localparam int NT = 7;
    localparam int NROWS = 13;

    typedef struct packed {
        logic [NT-1:0] sel;
        logic          stl;
        logic          done;
        logic [NS-1:0] ent;
        logic [NS-1:0] ext;
        logic [NS-1:0] act;
        logic [3:0]    req;
    } row_t;

    localparam row_t TBL [NROWS] = '{
        '{7'h00, 1'b0, 1'b0, 8'h03, 8'h00, 8'h03, 4'd10}, // R10 start-up
        '{7'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h03, 4'd10}, // R10 no repeat
        '{7'h01, 1'b0, 1'b0, 8'h14, 8'h02, 8'h15, 4'd8},  // R8 named initial
        '{7'h02, 1'b0, 1'b0, 8'h08, 8'h10, 8'h0D, 4'd9},  // R9 parent stays
        '{7'h02, 1'b0, 1'b0, 8'h00, 8'h00, 8'h0D, 4'd4},  // R4 target active
        '{7'h04, 1'b1, 1'b0, 8'hE0, 8'h0C, 8'h0D, 4'd2},  // R2 stalled step
        '{7'h04, 1'b0, 1'b0, 8'hE0, 8'h0C, 8'hE1, 4'd7},  // R7 regions
        '{7'h08, 1'b0, 1'b0, 8'h40, 8'h40, 8'hE1, 4'd4},  // R4 self
        '{7'h48, 1'b0, 1'b0, 8'hC0, 8'hC0, 8'hE1, 4'd7},  // R7 both regions
        '{7'h10, 1'b0, 1'b0, 8'h0C, 8'hE0, 8'h0D, 4'd8},  // R8 sibling target
        '{7'h20, 1'b0, 1'b0, 8'h02, 8'h0C, 8'h03, 4'd5},  // R5 back to idle
        '{7'h00, 1'b0, 1'b1, 8'h00, 8'h00, 8'h02, 4'd6},  // R6 root drops
        '{7'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h03, 4'd6}   // R6 root back
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall = 1'b0;
    logic          completed = 1'b0;
    logic [NT-1:0] trans_sel = '0;
    logic [NS-1:0] active_o;
    logic [NS-1:0] entry_o;
    logic [NS-1:0] exit_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    hsm_config_stepper u_dut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .completed(completed),
        .trans_sel(trans_sel), .active_o(active_o),
        .entry_o(entry_o), .exit_o(exit_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [NS-1:0] got, input logic [NS-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // one active child per active compound: root {1,2,5}, RUN {3,4}
    function automatic logic one_child_ok(input logic [NS-1:0] a);
        logic ok;
        ok = 1'b1;
        if (a[0] && ((32'(a[1]) + 32'(a[2]) + 32'(a[5])) != 1)) ok = 1'b0;
        if (a[2] && ((32'(a[3]) + 32'(a[4])) != 1)) ok = 1'b0;
        return ok;
    endfunction

    initial begin
        #(20 * 5000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", "active in reset", active_o, 8'h00);
        check("R10", "boot entry in reset", entry_o, 8'h03);
        rst_n = 1'b1;
        stall = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R2", "active held by stall", active_o, 8'h00);
        check("R10", "boot flag held by stall", entry_o, 8'h03);

        for (int i = 0; i < NROWS; i++) begin
            trans_sel = TBL[i].sel;
            stall     = TBL[i].stl;
            completed = TBL[i].done;
            #2;
            check($sformatf("R%0d", TBL[i].req), $sformatf("entry row %0d", i),
                  entry_o, TBL[i].ent);
            check($sformatf("R%0d", TBL[i].req), $sformatf("exit row %0d", i),
                  exit_o, TBL[i].ext);
            @(posedge clk);
            #2;
            check($sformatf("R%0d", TBL[i].req), $sformatf("active row %0d", i),
                  active_o, TBL[i].act);
            checks++;
            if (!one_child_ok(active_o)) begin
                errors++;
                $display("FAIL R11 one child row %0d: got %h expected 1", i, active_o);
            end
            @(negedge clk);
        end

        // R1 mid-run reset, then R10 start-up again
        trans_sel = '0;
        stall     = 1'b0;
        completed = 1'b0;
        rst_n     = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", "active after mid-run reset", active_o, 8'h00);
        check("R10", "boot entry after reset", entry_o, 8'h03);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R10", "active after restart", active_o, 8'h03);
        check("R10", "entry after restart", entry_o, 8'h00);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule